// File: doc/BRIEF.md
# Highside Output Fault Supervisor

This block supervises a bank of eight highside switched outputs that share one supply rail. For every channel it compares the commanded state against the channel's readback line. When the two disagree for long enough, it latches a fault for that channel. The most dangerous case is a channel that reads back energised while it is commanded off, such as a shorted switch. In that case the block also withdraws the shared rail enable, so that all eight outputs lose power.

A second monitor looks at the rail supply, given as an unsigned millivolt word. It latches a rail power fault when the reading sags to the threshold or below. Two situations mute the "commanded on but reads off" check: a switched-off rail and a low supply. In both, no output voltage can be expected. A detection-enable input stands for an auxiliary supply being switched off; while it is low, nothing is evaluated. Every latched flag, and the rail cutoff, clears only on the synchronous reset, which stands for cycling the machine's power.

Top module: `hso_supervisor`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `rail_en`=0, `chan_fault`=0, `rail_fault`=0 and `any_fault`=0.
- R2: A command bit of 1 means the channel is commanded on. A monitor bit of 0 means the channel reads back on, and a monitor bit of 1 means it reads back off.
- R3: A channel that is commanded off (`cmd_on[i]`=0) while reading back on (`mon_n[i]`=0), with `det_en`=1, sets `chan_fault[i]` at the SETTLE-th consecutive clock edge that sees that condition. Before that edge the bit stays 0. The default SETTLE is 8.
- R4: Any edge on which a channel shows no counted mismatch restarts that channel's persistence count from zero.
- R5: `rail_en` is `rail_req` registered by one clock edge. From the edge after a stuck-on fault latches (the R3 condition), it is held at 0.
- R6: A channel commanded on (`cmd_on[i]`=1) but reading back off (`mon_n[i]`=1) latches `chan_fault[i]` after the same SETTLE window, and it leaves `rail_en` untouched.
- R7: The commanded-on, reads-off condition is not counted while `rail_en` is 0.
- R8: When `det_en`=1 and `supply_mv` <= 18000 at a clock edge, `rail_fault` is 1 after that edge. A reading of 18001 does not set it.
- R9: While `supply_mv` <= 18000, the commanded-on, reads-off condition is not counted. The stuck-on condition is still counted.
- R10: While `det_en`=0, no mismatch is counted and no fault bit changes.
- R11: Once set, `chan_fault` bits, `rail_fault` and the rail cutoff remain set whatever the inputs do, until `rst`.
- R12: `any_fault` is 1 exactly when any bit of `chan_fault` or `rail_fault` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, standing for a power cycle |
| cmd_on | input | 8 | Per-channel command, 1 = on |
| mon_n | input | 8 | Per-channel readback, 0 = output energised |
| supply_mv | input | 16 | Rail supply reading in millivolts, unsigned |
| rail_req | input | 1 | Requested state of the shared rail enable |
| det_en | input | 1 | Detection enable; 0 skips all checks |
| rail_en | output | 1 | Registered, gated shared rail enable |
| chan_fault | output | 8 | Latched per-channel fault flags |
| rail_fault | output | 1 | Latched low-supply fault |
| any_fault | output | 1 | OR of all latched faults |

## Verification
Two effects can land on the same clock edge: a supply sag and a commanded-on, reads-off mismatch that is partway through its persistence window. The sag both latches the rail fault and freezes that channel's count at zero. The bench provokes this by holding the supply at exactly 18000 mV while one channel reads off against an on command and another reads on against an off command. It then judges that only the stuck-on channel latches and that the rail fault appears after the first such edge. Random phases repeat the overlap with sags of random timing against persistent mismatches, and every cycle is compared with a cycle model in the bench.

// File: rtl/hso_pkg.sv
package hso_pkg;

    localparam int CH_COUNT      = 8;
    localparam int SUPPLY_BITS   = 16;
    localparam int LOW_RAIL_MV   = 18000;
    localparam int SETTLE_CYCLES = 8;

    // Kind of disagreement seen on one channel in the current cycle
    typedef enum logic [1:0] {
        MIS_NONE      = 2'd0,
        MIS_STUCK_ON  = 2'd1,
        MIS_STUCK_OFF = 2'd2
    } mis_kind_e;

    // Retained state of one channel
    typedef struct packed {
        logic fault;
        logic stuck_on;
    } chan_stat_t;

    // Decide which mismatch, if any, counts toward the persistence window.
    // Readback is active low: mon_n == 0 means voltage present.
    function automatic mis_kind_e classify(
        input logic cmd,
        input logic mon_n,
        input logic rail_live,
        input logic sup_low,
        input logic det_en
    );
        mis_kind_e k;
        k = MIS_NONE;
        if (det_en) begin
            if (!cmd && !mon_n)
                k = MIS_STUCK_ON;
            else if (cmd && mon_n && rail_live && !sup_low)
                k = MIS_STUCK_OFF;
        end
        return k;
    endfunction

endpackage

// File: rtl/hso_supply_mon.sv
module hso_supply_mon #(
    parameter int SUP_W  = hso_pkg::SUPPLY_BITS,
    parameter int THRESH = hso_pkg::LOW_RAIL_MV
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             det_en,
    input  logic [SUP_W-1:0] supply_mv,
    output logic             sup_low,
    output logic             rail_fault
);

    localparam logic [SUP_W-1:0] LIMIT = SUP_W'(THRESH);

    // Inclusive compare: a reading equal to the limit is already low
    assign sup_low = (supply_mv <= LIMIT);

    always_ff @(posedge clk) begin
        if (rst)
            rail_fault <= 1'b0;
        else if (det_en && sup_low)
            rail_fault <= 1'b1;
    end

endmodule

// File: rtl/hso_chan_filter.sv
module hso_chan_filter
    import hso_pkg::*;
#(
    parameter int SETTLE = SETTLE_CYCLES
) (
    input  logic       clk,
    input  logic       rst,
    input  mis_kind_e  kind,
    output chan_stat_t stat
);

    localparam int            CW   = (SETTLE > 1) ? $clog2(SETTLE) : 1;
    localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

    logic [CW-1:0] run_q;

    // Count consecutive mismatch cycles; a gap restarts the count.
    // On the final cycle of the window the fault (and, for a stuck-on
    // readback, the cutoff request) is latched; the count then parks.
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
            stat  <= '0;
        end else if (kind == MIS_NONE) begin
            run_q <= '0;
        end else if (run_q == LAST) begin
            stat.fault <= 1'b1;
            if (kind == MIS_STUCK_ON)
                stat.stuck_on <= 1'b1;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

endmodule

// File: rtl/hso_rail_gate.sv
module hso_rail_gate #(
    parameter int N_CH = hso_pkg::CH_COUNT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rail_req,
    input  logic [N_CH-1:0] stuck_vec,
    output logic            rail_en
);

    // stuck_vec is already latched per channel, so the cutoff persists
    always_ff @(posedge clk) begin
        if (rst)
            rail_en <= 1'b0;
        else
            rail_en <= rail_req && !(|stuck_vec);
    end

endmodule

// File: rtl/hso_supervisor.sv
module hso_supervisor
    import hso_pkg::*;
#(
    parameter int N_CH      = CH_COUNT,
    parameter int SUP_W     = SUPPLY_BITS,
    parameter int THRESH_MV = LOW_RAIL_MV,
    parameter int SETTLE    = SETTLE_CYCLES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_CH-1:0]  cmd_on,
    input  logic [N_CH-1:0]  mon_n,
    input  logic [SUP_W-1:0] supply_mv,
    input  logic             rail_req,
    input  logic             det_en,
    output logic             rail_en,
    output logic [N_CH-1:0]  chan_fault,
    output logic             rail_fault,
    output logic             any_fault
);

    logic            sup_low;
    logic [N_CH-1:0] stuck_vec;
    mis_kind_e       kind [N_CH];
    chan_stat_t      stat [N_CH];

    hso_supply_mon #(
        .SUP_W  (SUP_W),
        .THRESH (THRESH_MV)
    ) u_supply (
        .clk        (clk),
        .rst        (rst),
        .det_en     (det_en),
        .supply_mv  (supply_mv),
        .sup_low    (sup_low),
        .rail_fault (rail_fault)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_chan
        assign kind[g] = classify(cmd_on[g], mon_n[g], rail_en, sup_low, det_en);

        hso_chan_filter #(
            .SETTLE (SETTLE)
        ) u_filt (
            .clk  (clk),
            .rst  (rst),
            .kind (kind[g]),
            .stat (stat[g])
        );

        assign chan_fault[g] = stat[g].fault;
        assign stuck_vec[g]  = stat[g].stuck_on;
    end

    hso_rail_gate #(
        .N_CH (N_CH)
    ) u_gate (
        .clk       (clk),
        .rst       (rst),
        .rail_req  (rail_req),
        .stuck_vec (stuck_vec),
        .rail_en   (rail_en)
    );

    assign any_fault = (|chan_fault) | rail_fault;

endmodule

// File: rtl/hso_checker.sv
module hso_checker #(
    parameter int N_CH      = 8,
    parameter int SUP_W     = 16,
    parameter int THRESH_MV = 18000
) (
    input logic             clk,
    input logic             rst,
    input logic [SUP_W-1:0] supply_mv,
    input logic             rail_req,
    input logic             det_en,
    input logic             rail_en,
    input logic [N_CH-1:0]  chan_fault,
    input logic             rail_fault
);

    localparam logic [SUP_W-1:0] LIMIT = SUP_W'(THRESH_MV);

    assert_req_low_gates_R5: assert property (@(posedge clk) disable iff (rst)
        !rail_req |=> !rail_en);

    assert_chan_retained_R11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((chan_fault & $past(chan_fault)) == $past(chan_fault)));

    assert_rail_fault_retained_R11: assert property (@(posedge clk) disable iff (rst)
        rail_fault |=> rail_fault);

    assert_low_supply_latch_R8: assert property (@(posedge clk) disable iff (rst)
        (det_en && (supply_mv <= LIMIT)) |=> rail_fault);

    assert_no_detect_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        !det_en |=> (chan_fault == $past(chan_fault)) && (rail_fault == $past(rail_fault)));

endmodule

bind hso_supervisor hso_checker #(
    .N_CH      (N_CH),
    .SUP_W     (SUP_W),
    .THRESH_MV (THRESH_MV)
) u_hso_checker (
    .clk        (clk),
    .rst        (rst),
    .supply_mv  (supply_mv),
    .rail_req   (rail_req),
    .det_en     (det_en),
    .rail_en    (rail_en),
    .chan_fault (chan_fault),
    .rail_fault (rail_fault)
);

// File: tb/test_hso_supervisor.sv
module test_hso_supervisor;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;
    localparam int SW  = 16;
    localparam int THR = 18000;
    localparam int SET = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NCH-1:0] cmd_on = '0;
    logic [NCH-1:0] mon_n  = '1;
    logic [SW-1:0]  supply_mv = 16'd24000;
    logic           rail_req = 1'b0;
    logic           det_en   = 1'b1;

    logic           rail_en;
    logic [NCH-1:0] chan_fault;
    logic           rail_fault;
    logic           any_fault;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hso_supervisor #(
        .N_CH      (NCH),
        .SUP_W     (SW),
        .THRESH_MV (THR),
        .SETTLE    (SET)
    ) i_hso_supervisor (
        .clk        (clk),
        .rst        (rst),
        .cmd_on     (cmd_on),
        .mon_n      (mon_n),
        .supply_mv  (supply_mv),
        .rail_req   (rail_req),
        .det_en     (det_en),
        .rail_en    (rail_en),
        .chan_fault (chan_fault),
        .rail_fault (rail_fault),
        .any_fault  (any_fault)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Bench model state, built from the requirements
    int             m_run [NCH];
    logic [NCH-1:0] m_fault = '0;
    logic [NCH-1:0] m_son   = '0;
    logic           m_rail  = 1'b0;
    logic           m_rfault = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic is_low(input logic [SW-1:0] s);
        return s <= 16'(THR);
    endfunction

    // Apply one clock edge to the model using the inputs now on the pins
    task automatic model_edge();
        logic           lo;
        logic [NCH-1:0] f;
        logic [NCH-1:0] s;
        logic           r;
        if (rst) begin
            for (int i = 0; i < NCH; i++) m_run[i] = 0;
            m_fault  = '0;
            m_son    = '0;
            m_rail   = 1'b0;
            m_rfault = 1'b0;
        end else begin
            lo = is_low(supply_mv);
            f  = m_fault;
            s  = m_son;
            for (int i = 0; i < NCH; i++) begin
                bit on_bad;
                bit off_bad;
                on_bad  = det_en && !cmd_on[i] && !mon_n[i];
                off_bad = det_en && cmd_on[i] && mon_n[i] && m_rail && !lo;
                if (!(on_bad || off_bad))
                    m_run[i] = 0;
                else if (m_run[i] == SET - 1) begin
                    f[i] = 1'b1;
                    if (on_bad) s[i] = 1'b1;
                end else
                    m_run[i]++;
            end
            r = rail_req && !(|m_son);
            if (det_en && lo) m_rfault = 1'b1;
            m_fault = f;
            m_son   = s;
            m_rail  = r;
        end
    endtask

    task automatic compare_all();
        chk("R3 chan_fault vs model", 32'(chan_fault), 32'(m_fault));
        chk("R5 rail_en vs model", 32'(rail_en), 32'(m_rail));
        chk("R8 rail_fault vs model", 32'(rail_fault), 32'(m_rfault));
        chk("R12 any_fault vs model", 32'(any_fault), 32'((|m_fault) | m_rfault));
    endtask

    task automatic step(input logic r, input logic rq, input logic de,
                        input logic [NCH-1:0] c, input logic [NCH-1:0] m,
                        input logic [SW-1:0] s);
        @(negedge clk);
        rst = r; rail_req = rq; det_en = de; cmd_on = c; mon_n = m; supply_mv = s;
        @(posedge clk);
        model_edge();
        #1;
        compare_all();
    endtask

    task automatic do_reset();
        repeat (3) step(1'b1, 1'b1, 1'b1, '0, '1, 16'd24000);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            report();
            $finish;
        end
    end

    initial begin
        logic [NCH-1:0] c_r;
        logic [NCH-1:0] bad_r;
        logic [SW-1:0]  s_r;
        logic           de_r;
        logic           rq_r;
        void'($urandom(32'd4242));
        for (int i = 0; i < NCH; i++) m_run[i] = 0;

        // R1: reset state
        do_reset();
        chk("R1 rail_en in reset", 32'(rail_en), 32'd0);
        chk("R1 chan_fault in reset", 32'(chan_fault), 32'd0);
        chk("R1 fault flags in reset", 32'({rail_fault, any_fault}), 32'd0);
        step(1'b0, 1'b1, 1'b1, '0, '1, 16'd24000);
        chk("R5 rail_en follows request", 32'(rail_en), 32'd1);

        // R3/R2: stuck-on on channel 2, window boundary
        repeat (SET - 1) step(1'b0, 1'b1, 1'b1, '0, 8'hFB, 16'd24000);
        chk("R3 no fault before window ends", 32'(chan_fault), 32'd0);
        step(1'b0, 1'b1, 1'b1, '0, 8'hFB, 16'd24000);
        chk("R2 R3 stuck-on latched ch2", 32'(chan_fault), 32'h04);
        chk("R5 rail still on at latch edge", 32'(rail_en), 32'd1);
        step(1'b0, 1'b1, 1'b1, '0, '1, 16'd24000);
        chk("R5 rail cut edge after latch", 32'(rail_en), 32'd0);
        repeat (4) step(1'b0, 1'b1, 1'b1, '0, '1, 16'd24000);
        chk("R11 chan fault retained", 32'(chan_fault), 32'h04);
        chk("R11 cutoff retained", 32'(rail_en), 32'd0);
        do_reset();
        chk("R11 reset clears faults", 32'(chan_fault), 32'd0);

        // R4: interrupted mismatch restarts the count
        step(1'b0, 1'b1, 1'b1, '0, '1, 16'd24000);
        repeat (SET - 1) step(1'b0, 1'b1, 1'b1, '0, 8'hDF, 16'd24000);
        step(1'b0, 1'b1, 1'b1, '0, '1, 16'd24000);
        repeat (SET - 1) step(1'b0, 1'b1, 1'b1, '0, 8'hDF, 16'd24000);
        chk("R4 gap restarts count", 32'(chan_fault), 32'd0);
        step(1'b0, 1'b1, 1'b1, '0, 8'hDF, 16'd24000);
        chk("R4 full window latches ch5", 32'(chan_fault), 32'h20);

        // R6: commanded on, reads off
        do_reset();
        step(1'b0, 1'b1, 1'b1, '0, '1, 16'd24000);
        repeat (SET) step(1'b0, 1'b1, 1'b1, 8'h02, '1, 16'd24000);
        chk("R6 stuck-off latched ch1", 32'(chan_fault), 32'h02);
        step(1'b0, 1'b1, 1'b1, 8'h02, '1, 16'd24000);
        chk("R6 rail not cut", 32'(rail_en), 32'd1);

        // R7: rail off masks stuck-off
        do_reset();
        repeat (2) step(1'b0, 1'b0, 1'b1, '0, '1, 16'd24000);
        repeat (SET + 2) step(1'b0, 1'b0, 1'b1, 8'h01, '1, 16'd24000);
        chk("R7 no fault with rail off", 32'(chan_fault), 32'd0);

        // R8 threshold and R9 overlap with mismatches
        do_reset();
        step(1'b0, 1'b1, 1'b1, '0, '1, 16'd24000);
        repeat (3) step(1'b0, 1'b1, 1'b1, '0, '1, 16'd18001);
        chk("R8 18001 mV not low", 32'(rail_fault), 32'd0);
        step(1'b0, 1'b1, 1'b1, 8'h08, 8'hEF, 16'd18000);
        chk("R8 18000 mV latches", 32'(rail_fault), 32'd1);
        repeat (SET + 1) step(1'b0, 1'b1, 1'b1, 8'h08, 8'hEF, 16'd18000);
        chk("R9 only stuck-on counted in sag", 32'(chan_fault), 32'h10);

        // R10: detection disabled
        do_reset();
        step(1'b0, 1'b1, 1'b1, '0, '1, 16'd24000);
        repeat (SET + 3) step(1'b0, 1'b1, 1'b0, 8'h02, 8'hFE, 16'd1000);
        chk("R10 no channel fault", 32'(chan_fault), 32'd0);
        chk("R10 no rail fault", 32'(rail_fault), 32'd0);
        chk("R10 rail kept on", 32'(rail_en), 32'd1);

        // Random phase with persistent faults, sags and resets
        c_r   = '0;
        bad_r = '0;
        for (int k = 0; k < 3000; k++) begin
            if ((k % 6) == 0) c_r = NCH'($urandom);
            if ((k % 20) == 0)
                bad_r = (($urandom % 3) == 0) ? NCH'(1 << ($urandom % NCH)) : '0;
            s_r  = (($urandom % 16) == 0) ? SW'(17000 + ($urandom % 1500))
                                          : SW'(18500 + ($urandom % 12000));
            de_r = (($urandom % 8) != 0);
            rq_r = (($urandom % 16) != 0);
            step((k % 64) < 2, rq_r, de_r, c_r, ~c_r ^ bad_r, s_r);
        end

        done = 1'b1;
        report();
        $finish;
    end

endmodule